// File: doc/BRIEF.md
# Multi-slot branch direction predictor

This block predicts taken or not-taken for every instruction slot of a fetch bundle in a superscalar front end. A table of 2-bit saturating counters is indexed by hashing each slot's address with a speculative global history register. The fetch stage presents the address of the next bundle one cycle before it needs the answers. The predictor launches all slot reads in that cycle, and the results are registered and ready in the following cycle.

The block keeps no per-slot address. Slot `i` is looked up at the bundle base address plus `4*i`, whether or not an instruction really sits there. For this reason every prediction carries the table index it used. The backend returns that index with the resolved outcome, so training always lands on the entry that produced the prediction.

The global history is advanced when fetch consumes a bundle. Only slots where fetch saw a branch take part, and the bit recorded for each is the direction prediction. The computed next address plays no part. A checkpointed history can be loaded back on a misprediction. Indexing uses plain addresses only.

Top module: `multi_slot_dir_pred`

## Requirements
- R1: After reset, `pred_valid_o` is 0, `ghist_o` is 0, the slot outputs are 0, and every counter holds 1 (weakly not-taken), so an untrained entry predicts not-taken.
- R2: A cycle with `lookup_i` high makes `pred_valid_o` high in the next cycle. Otherwise `pred_valid_o` is low in the next cycle. When no lookup is launched, `pred_idx_o` and `pred_taken_o` keep their previous values.
- R3: The index for slot `i` equals bits `[IDX_W+1:2]` of `(next_pc_i + 4*i)` XOR the low `IDX_W` bits of the history, sampled in the lookup cycle. It is presented at `pred_idx_o[i*IDX_W +: IDX_W]`.
- R4: `pred_taken_o[i]` is the upper bit of the counter at slot `i`'s index, as that counter stood in the lookup cycle.
- R5: With `train_valid_i` high, the counter at `train_idx_i` is incremented when `train_taken_i` is 1 and decremented when it is 0. It saturates at 0 and 3, and lookups see the new value from the next cycle on.
- R6: When a training write and a lookup read use the same index in the same cycle, the lookup returns the counter value from before the write.
- R7: When `consume_i` and `pred_valid_o` are both high, the history shifts left once for each slot with `fetch_br_i[i]` set, in ascending slot order. The new LSB is `pred_taken_o[i]`, and shifting stops after the first such slot that is predicted taken.
- R8: If no restore occurs, and either no bundle is consumed or no slot of it has `fetch_br_i` set, the history is unchanged.
- R9: `restore_i` loads `restore_hist_i` into the history at the next edge. It takes priority over any shift in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| lookup_i | input | 1 | Launch a lookup for the bundle at `next_pc_i` |
| next_pc_i | input | ADDR_W | Base address of the next bundle |
| pred_valid_o | output | 1 | Slot predictions are fresh this cycle |
| pred_taken_o | output | SLOTS | Per-slot taken prediction |
| pred_idx_o | output | SLOTS*IDX_W | Per-slot table index used |
| consume_i | input | 1 | Fetch consumes the current predictions |
| fetch_br_i | input | SLOTS | Fetch saw a branch in this slot |
| restore_i | input | 1 | Reload history from checkpoint |
| restore_hist_i | input | IDX_W | Checkpointed history value |
| ghist_o | output | IDX_W | Current speculative history |
| train_valid_i | input | 1 | Training update present |
| train_idx_i | input | IDX_W | Index returned from the lookup |
| train_taken_i | input | 1 | Resolved direction |

## Verification
Lookup results (R2 to R4, R6) appear one edge after the lookup cycle. History changes (R7 to R9) take effect one edge after the consume or restore cycle. A counter change from training (R5) is seen by a lookup launched on or after the edge that writes it. The bench keeps a behavioural model of the table, the history and the output registers. It applies each cycle's inputs to the model at the same edge as the design, then compares every output at the following falling edge. Training indices are often chosen to equal a slot index looked up in the same cycle, which exercises the read-before-write case.

// File: rtl/bp_dir_pkg.sv
package bp_dir_pkg;
  typedef logic [1:0] ctr_t;
  localparam ctr_t CTR_RESET = 2'b01;

  function automatic ctr_t ctr_step(ctr_t c, logic taken);
    if (taken) return (c == 2'b11) ? c : c + 2'd1;
    else       return (c == 2'b00) ? c : c - 2'd1;
  endfunction
endpackage

// File: rtl/bp_ctr_table.sv
module bp_ctr_table
  import bp_dir_pkg::*;
#(
  parameter int IDX_W    = 6,
  parameter int RD_PORTS = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             rd_en_i,
  input  logic [IDX_W-1:0] rd_idx_i [RD_PORTS],
  output ctr_t             rd_ctr_o [RD_PORTS],
  input  logic             wr_en_i,
  input  logic [IDX_W-1:0] wr_idx_i,
  input  ctr_t             wr_ctr_i,
  output ctr_t             wr_cur_o
);
  localparam int DEPTH = 1 << IDX_W;

  ctr_t mem_q [DEPTH];
  ctr_t rd_q  [RD_PORTS];

  assign wr_cur_o = mem_q[wr_idx_i];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < DEPTH; k++) mem_q[k] <= CTR_RESET;
    end else if (wr_en_i) begin
      mem_q[wr_idx_i] <= wr_ctr_i;
    end
  end

  // registered read: a same-edge write is not visible (old value)
  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)      rd_q[p] <= '0;
      else if (rd_en_i) rd_q[p] <= mem_q[rd_idx_i[p]];
    end
    assign rd_ctr_o[p] = rd_q[p];
  end

  p_write_lands_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_en_i |=> mem_q[$past(wr_idx_i)] == $past(wr_ctr_i));

  p_read_old_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_en_i && wr_en_i && rd_idx_i[0] == wr_idx_i && wr_ctr_i != wr_cur_o)
      |=> rd_q[0] != mem_q[$past(wr_idx_i)]);
endmodule

// File: rtl/bp_ghist.sv
module bp_ghist #(
  parameter int HIST_W = 6,
  parameter int SLOTS  = 4
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              upd_en_i,
  input  logic [SLOTS-1:0]  br_i,
  input  logic [SLOTS-1:0]  taken_i,
  input  logic              restore_i,
  input  logic [HIST_W-1:0] restore_hist_i,
  output logic [HIST_W-1:0] ghist_o
);
  logic [HIST_W-1:0] ghist_q, ghist_d;

  always_comb begin
    logic stop;
    stop    = 1'b0;
    ghist_d = ghist_q;
    if (restore_i) begin
      ghist_d = restore_hist_i;
    end else if (upd_en_i) begin
      for (int s = 0; s < SLOTS; s++) begin
        if (!stop && br_i[s]) begin
          ghist_d = {ghist_d[HIST_W-2:0], taken_i[s]};
          stop    = taken_i[s];
        end
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ghist_q <= '0;
    else         ghist_q <= ghist_d;
  end

  assign ghist_o = ghist_q;

  p_restore_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    restore_i |=> ghist_q == $past(restore_hist_i));

  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restore_i && (!upd_en_i || br_i == '0)) |=> $stable(ghist_q));

  p_lsb_from_slot0_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!restore_i && upd_en_i && br_i[0] && taken_i[0])
      |=> ghist_q == {$past(ghist_q[HIST_W-2:0]), 1'b1});
endmodule

// File: rtl/multi_slot_dir_pred.sv
module multi_slot_dir_pred
  import bp_dir_pkg::*;
#(
  parameter int SLOTS  = 4,
  parameter int IDX_W  = 6,
  parameter int ADDR_W = 32
) (
  input  logic                   clk_i,
  input  logic                   rst_ni,
  input  logic                   lookup_i,
  input  logic [ADDR_W-1:0]      next_pc_i,
  output logic                   pred_valid_o,
  output logic [SLOTS-1:0]       pred_taken_o,
  output logic [SLOTS*IDX_W-1:0] pred_idx_o,
  input  logic                   consume_i,
  input  logic [SLOTS-1:0]       fetch_br_i,
  input  logic                   restore_i,
  input  logic [IDX_W-1:0]       restore_hist_i,
  output logic [IDX_W-1:0]       ghist_o,
  input  logic                   train_valid_i,
  input  logic [IDX_W-1:0]       train_idx_i,
  input  logic                   train_taken_i
);
  localparam int HIST_W = IDX_W;

  logic [IDX_W-1:0]  idx_d [SLOTS];
  ctr_t              rd_ctr [SLOTS];
  ctr_t              train_cur;
  logic [HIST_W-1:0] ghist;
  logic [SLOTS*IDX_W-1:0] idx_q;
  logic              valid_q;

  // slot address = base + 4*slot; no per-slot PC
  for (genvar s = 0; s < SLOTS; s++) begin : g_slot
    logic [ADDR_W-1:0] slot_pc;
    assign slot_pc         = next_pc_i + ADDR_W'(4 * s);
    assign idx_d[s]        = slot_pc[IDX_W+1:2] ^ ghist[IDX_W-1:0];
    assign pred_taken_o[s] = rd_ctr[s][1];
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       idx_q[s*IDX_W +: IDX_W] <= '0;
      else if (lookup_i) idx_q[s*IDX_W +: IDX_W] <= idx_d[s];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) valid_q <= 1'b0;
    else         valid_q <= lookup_i;
  end

  bp_ctr_table #(.IDX_W(IDX_W), .RD_PORTS(SLOTS)) u_table (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .rd_en_i  (lookup_i),
    .rd_idx_i (idx_d),
    .rd_ctr_o (rd_ctr),
    .wr_en_i  (train_valid_i),
    .wr_idx_i (train_idx_i),
    .wr_ctr_i (ctr_step(train_cur, train_taken_i)),
    .wr_cur_o (train_cur)
  );

  bp_ghist #(.HIST_W(HIST_W), .SLOTS(SLOTS)) u_ghist (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .upd_en_i       (consume_i && valid_q),
    .br_i           (fetch_br_i),
    .taken_i        (pred_taken_o),
    .restore_i      (restore_i),
    .restore_hist_i (restore_hist_i),
    .ghist_o        (ghist)
  );

  assign ghist_o      = ghist;
  assign pred_valid_o = valid_q;
  assign pred_idx_o   = idx_q;

  p_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !lookup_i |=> ($stable(pred_idx_o) && $stable(pred_taken_o) && !pred_valid_o));

  p_fresh_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    lookup_i |=> pred_valid_o);
endmodule

// File: tb/multi_slot_dir_pred_bench.sv
module multi_slot_dir_pred_bench;
  localparam int SLOTS = 4, IDX_W = 6, ADDR_W = 32;
  localparam int DEPTH = 1 << IDX_W;
  localparam int MASK  = DEPTH - 1;

  logic clk = 0, rst_n = 0;
  logic lookup = 0, consume = 0, restore = 0, tv = 0, tt = 0;
  logic [ADDR_W-1:0] npc = '0;
  logic [SLOTS-1:0] fbr = '0;
  logic [IDX_W-1:0] rhist = '0, tidx = '0;
  logic pvalid;
  logic [SLOTS-1:0] ptaken;
  logic [SLOTS*IDX_W-1:0] pidx;
  logic [IDX_W-1:0] ghist;

  always #5 clk = ~clk;

  multi_slot_dir_pred #(.SLOTS(SLOTS), .IDX_W(IDX_W), .ADDR_W(ADDR_W)) u_multi_slot_dir_pred (
    .clk_i(clk), .rst_ni(rst_n), .lookup_i(lookup), .next_pc_i(npc),
    .pred_valid_o(pvalid), .pred_taken_o(ptaken), .pred_idx_o(pidx),
    .consume_i(consume), .fetch_br_i(fbr), .restore_i(restore),
    .restore_hist_i(rhist), .ghist_o(ghist), .train_valid_i(tv),
    .train_idx_i(tidx), .train_taken_i(tt));

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(string req, longint act, longint exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // behavioural reference state (m_*) and next state (n_*)
  int m_tab[DEPTH], n_tab[DEPTH];
  int m_ghr, n_ghr, m_valid, n_valid;
  int m_idx[SLOTS], n_idx[SLOTS], m_tk[SLOTS], n_tk[SLOTS];
  bit m_coll[SLOTS], n_coll[SLOTS];
  string m_hl, n_hl;

  initial begin
    #(64'd200000 * 10);
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int k = 0; k < DEPTH; k++) begin m_tab[k] = 1; n_tab[k] = 1; end
    m_ghr = 0; n_ghr = 0; m_valid = 0; n_valid = 0; m_hl = "R8"; n_hl = "R8";
    for (int s = 0; s < SLOTS; s++) begin
      m_idx[s] = 0; n_idx[s] = 0; m_tk[s] = 0; n_tk[s] = 0; m_coll[s] = 0; n_coll[s] = 0;
    end
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 valid", pvalid, 0);
    chk("R1 ghist", ghist, 0);
    chk("R1 idx", pidx, 0);
    chk("R1 taken", ptaken, 0);
    rst_n = 1;

    for (int cyc = 0; cyc < 6000; cyc++) begin
      @(negedge clk);
      m_tab = n_tab; m_ghr = n_ghr; m_valid = n_valid; m_hl = n_hl;
      m_idx = n_idx; m_tk = n_tk; m_coll = n_coll;

      chk("R2 valid", pvalid, m_valid);
      chk(m_hl, ghist, m_ghr);
      for (int s = 0; s < SLOTS; s++) begin
        chk("R3 idx", pidx[s*IDX_W +: IDX_W], m_idx[s]);
        if (m_coll[s]) chk("R6 taken", ptaken[s], m_tk[s]);
        else if (cyc < 8) chk("R1 taken", ptaken[s], m_tk[s]);
        else chk("R4,R5 taken", ptaken[s], m_tk[s]);
      end

      // new stimulus
      lookup  = ($urandom_range(0, 3) != 0);
      case ($urandom_range(0, 3))
        0: npc = 32'h0000_1000;
        1: npc = 32'h0000_1004;
        2: npc = 32'h0000_2010;
        default: npc = $urandom;
      endcase
      consume = $urandom_range(0, 1);
      fbr     = SLOTS'($urandom);
      restore = ($urandom_range(0, 19) == 0);
      rhist   = IDX_W'($urandom);
      tv      = ($urandom_range(0, 2) != 0);
      tt      = ($urandom_range(0, 9) < 7);

      // model: lookup with current history and pre-write table
      n_tab = m_tab;
      n_valid = lookup;
      for (int s = 0; s < SLOTS; s++) begin
        logic [ADDR_W-1:0] a;
        a = npc + ADDR_W'(4 * s);
        n_idx[s] = lookup ? (int'(a[31:2]) & MASK) ^ (m_ghr & MASK) : m_idx[s];
        n_coll[s] = 0;
      end
      tidx = ($urandom_range(0, 1) != 0) ? IDX_W'(n_idx[$urandom_range(0, SLOTS-1)])
                                         : IDX_W'($urandom);
      for (int s = 0; s < SLOTS; s++) begin
        if (lookup) begin
          n_tk[s] = (m_tab[n_idx[s]] >= 2);
          n_coll[s] = tv && (int'(tidx) == n_idx[s]);
        end else begin
          n_tk[s] = m_tk[s];
        end
      end
      if (tv) begin
        if (tt) n_tab[tidx] = (m_tab[tidx] == 3) ? 3 : m_tab[tidx] + 1;
        else    n_tab[tidx] = (m_tab[tidx] == 0) ? 0 : m_tab[tidx] - 1;
      end
      // model: history
      n_ghr = m_ghr; n_hl = "R8 ghist";
      if (restore) begin
        n_ghr = rhist; n_hl = "R9 ghist";
      end else if (consume && m_valid != 0) begin
        for (int s = 0; s < SLOTS; s++) begin
          if (fbr[s]) begin
            n_ghr = ((n_ghr << 1) | m_tk[s]) & MASK;
            n_hl = "R7 ghist";
            if (m_tk[s] != 0) break;
          end
        end
      end
    end

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule